// File: doc/BRIEF.md
# Replay FIFO with Half-Full Flag

This block is a single-clock first-in/first-out buffer for 9-bit words. Writes and reads arrive as synchronous request enables. Ring pointers walk the storage, so the caller never supplies an address. Three active-low flags report the state of the buffer: empty, full and more-than-half-full. Every flag is a register that is updated from the occupancy the buffer will have after the current edge.

A rewind input moves the read pointer back to location zero and leaves the write pointer where it is. Everything stored since reset can then be read out again, as long as the buffer has not wrapped. Read data comes out one cycle after an accepted read, together with an output-enable strobe. While that strobe is low the data bus holds zero, which stands in for a released tri-state bus. The storage depth is a parameter.

Top module: `replay_fifo`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, empty_no = 0, full_no = 1, half_no = 1, rdata_oe_o = 0 and rdata_o = 0. Both pointers start at location zero.
- R2: A write request while full_no = 0 is dropped. It changes neither the storage, the pointers nor the occupancy, so the words read out afterwards are the ones stored before it.
- R3: A read request while empty_no = 0 is dropped. rdata_oe_o stays 0 on the next cycle and the read pointer does not move.
- R4: Starting from reset with no reads, full_no goes to 0 after exactly DEPTH accepted writes and not before.
- R5: half_no goes to 0 after the accepted write that raises the occupancy above DEPTH/2. It goes back to 1 after the accepted read that brings the occupancy down to DEPTH/2 or less.
- R6: A rewind puts the read pointer at location zero and leaves the write pointer alone. The flags are then recomputed: the occupancy becomes the number of words written since reset, or DEPTH if the buffer has wrapped. The stored words are then read out again from the first one.
- R7: A rewind is ignored in any cycle where wr_i or rd_i is also high. In that cycle the read or write request is handled as usual.
- R8: The cycle after an accepted read, rdata_oe_o = 1 and rdata_o carries the oldest stored word. In every other cycle rdata_oe_o = 0 and rdata_o = 0.
- R9: When the buffer is full, a read deasserts full_no on the next cycle. A write in that next cycle is then accepted.
- R10: A cycle with both a read and a write accepted leaves the occupancy, and so all three flags, unchanged. Both words keep FIFO order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write request |
| wdata_i | input | 9 | Word to store |
| rd_i | input | 1 | Read request |
| rewind_i | input | 1 | Rewind the read pointer to location zero |
| rdata_o | output | 9 | Read word; zero when not enabled |
| rdata_oe_o | output | 1 | rdata_o is driven |
| empty_no | output | 1 | Empty flag, active low |
| full_no | output | 1 | Full flag, active low |
| half_no | output | 1 | More than half full, active low |

## Verification
Every result of the block appears exactly one clock edge after the request that causes it. This covers the three flags, the output enable and the read word, which are all registered off the same edge. The bench drives requests on the falling edge and steps its queue model at the same moment. It then compares every output with the model on the next falling edge, half a period after the edge that updates the design. This keeps each comparison clear of the edge where the outputs change, and it tests the one-cycle delay on every cycle rather than only at chosen points.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/replay_fifo_ptrs.sv
module replay_fifo_ptrs #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ok_i,
  input  logic          rd_ok_i,
  input  logic          rew_ok_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] cnt_next_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrapped_q;

  always_comb begin
    cnt_d = cnt_q;
    if (rew_ok_i) begin
      cnt_d = wrapped_q ? CW'(DEPTH) : CW'(wptr_q);
    end else if (wr_ok_i && !rd_ok_i) begin
      cnt_d = cnt_q + CW'(1);
    end else if (rd_ok_i && !wr_ok_i) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      cnt_q     <= '0;
      wrapped_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (wr_ok_i) begin
        wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + AW'(1);
        if (wptr_q == LAST) wrapped_q <= 1'b1;
      end
      if (rew_ok_i) rptr_q <= '0;
      else if (rd_ok_i) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + AW'(1);
    end
  end

  assign wptr_o     = wptr_q;
  assign rptr_o     = rptr_q;
  assign cnt_next_o = cnt_d;
endmodule

// File: rtl/replay_fifo_store.sv
module replay_fifo_store
  import replay_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ok_i,
  input  logic [AW-1:0] wptr_i,
  input  word_t         wdata_i,
  input  logic          rd_ok_i,
  input  logic [AW-1:0] rptr_i,
  output word_t         rdata_o,
  output logic          oe_o
);
  word_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_ok_i) mem[wptr_i] <= wdata_i;
  end

  // bus released (zero) unless a read was taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      oe_o    <= 1'b0;
    end else begin
      oe_o    <= rd_ok_i;
      rdata_o <= rd_ok_i ? mem[rptr_i] : '0;
    end
  end
endmodule

// File: rtl/replay_fifo_flags.sv
module replay_fifo_flags #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_next_i,
  output logic          empty_no,
  output logic          full_no,
  output logic          half_no
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [CW-1:0] TOP  = CW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_no <= 1'b0;
      full_no  <= 1'b1;
      half_no  <= 1'b1;
    end else begin
      empty_no <= (cnt_next_i != '0);
      full_no  <= (cnt_next_i != TOP);
      half_no  <= (cnt_next_i <= HALF);
    end
  end
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
  import replay_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              rewind_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              empty_no,
  output logic              full_no,
  output logic              half_no
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          wr_ok, rd_ok, rew_ok;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_next;

  assign wr_ok  = wr_i & full_no;
  assign rd_ok  = rd_i & empty_no;
  assign rew_ok = rewind_i & ~wr_i & ~rd_i;

  replay_fifo_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ok_i    (wr_ok),
    .rd_ok_i    (rd_ok),
    .rew_ok_i   (rew_ok),
    .wptr_o     (wptr),
    .rptr_o     (rptr),
    .cnt_next_o (cnt_next)
  );

  replay_fifo_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_ok_i (wr_ok),
    .wptr_i  (wptr),
    .wdata_i (wdata_i),
    .rd_ok_i (rd_ok),
    .rptr_i  (rptr),
    .rdata_o (rdata_o),
    .oe_o    (rdata_oe_o)
  );

  replay_fifo_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_next_i (cnt_next),
    .empty_no   (empty_no),
    .full_no    (full_no),
    .half_no    (half_no)
  );
endmodule

// File: rtl/replay_fifo_chk.sv
module replay_fifo_chk
  import replay_fifo_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic              rewind_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              rdata_oe_o,
  input logic              empty_no,
  input logic              full_no,
  input logic              half_no
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && wr_i && !rd_i) |=> !full_no); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_no && rd_i && !wr_i) |=> (!empty_no && !rdata_oe_o)); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!empty_no && !full_no)); // R4
  AST_HALF_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> !half_no); // R5
  AST_REWIND_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rewind_i && rd_i && empty_no) |=> rdata_oe_o); // R7
  AST_OE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> $past(rd_i && empty_no)); // R8
  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> (rdata_o == '0)); // R8
  AST_FULL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && rd_i && !wr_i) |=> full_no); // R9
  AST_BOTH_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i && empty_no && full_no) |=> ($stable(empty_no) && $stable(full_no) && $stable(half_no))); // R10
endmodule

bind replay_fifo replay_fifo_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rewind_i   (rewind_i),
  .rdata_o    (rdata_o),
  .rdata_oe_o (rdata_oe_o),
  .empty_no   (empty_no),
  .full_no    (full_no),
  .half_no    (half_no)
);

// File: tb/replay_fifo_bench.sv
`timescale 1ns/1ps
module replay_fifo_bench;
  localparam int DEPTH = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, rewind_i = 1'b0;
  logic [8:0] wdata_i = '0;
  logic [8:0] rdata_o;
  logic       rdata_oe_o, empty_no, full_no, half_no;

  int n_chk = 0, n_fail = 0;
  int q[$];
  int img[DEPTH];
  int total = 0;
  int exp_oe = 0, exp_data = 0;
  string req = "R1";

  always #4 clk_i = ~clk_i;

  replay_fifo #(.DEPTH(DEPTH)) u_replay_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .rewind_i(rewind_i), .rdata_o(rdata_o),
    .rdata_oe_o(rdata_oe_o), .empty_no(empty_no), .full_no(full_no),
    .half_no(half_no)
  );

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int cnt = q.size();
    chk("empty_no", int'(empty_no), (cnt != 0) ? 1 : 0);
    chk("full_no",  int'(full_no),  (cnt != DEPTH) ? 1 : 0);
    chk("half_no",  int'(half_no),  (cnt <= DEPTH / 2) ? 1 : 0);
    chk("oe",       int'(rdata_oe_o), exp_oe);
    chk("rdata",    int'(rdata_o),    exp_oe ? exp_data : 0);
  endtask

  // called at a falling edge: drive, update model, compare at next falling edge
  task automatic step(bit w, int d, bit r, bit rt);
    bit acc_w = w && (q.size() < DEPTH);
    bit acc_r = r && (q.size() > 0);
    wr_i = w; wdata_i = 9'(d); rd_i = r; rewind_i = rt;
    exp_oe = acc_r;
    exp_data = acc_r ? q[0] : 0;
    if (acc_r) void'(q.pop_front());
    if (acc_w) begin
      q.push_back(d);
      img[total % DEPTH] = d;
      total++;
    end
    if (rt && !w && !r) begin
      int c = (total >= DEPTH) ? DEPTH : total;
      q.delete();
      for (int i = 0; i < c; i++) q.push_back(img[i]);
    end
    @(negedge clk_i);
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_i = 0; rd_i = 0; rewind_i = 0;
    q.delete(); total = 0; exp_oe = 0;
    @(negedge clk_i);
    compare();
    rst_ni = 1'b1;
    compare();
  endtask

  initial begin
    int guard = 0;
    forever begin
      @(posedge clk_i);
      guard++;
      if (guard > 20000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", guard, 20000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    req = "R1";
    repeat (2) @(negedge clk_i);
    do_reset();
    req = "R3";
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    req = "R4 R5";
    for (int i = 0; i < DEPTH; i++) step(1, 9'h100 + i * 7, 0, 0);
    req = "R2";
    step(1, 9'h1AA, 0, 0);
    step(1, 9'h0AA, 0, 0);
    req = "R9";
    step(0, 0, 1, 0);
    step(1, 9'h055, 0, 0);
    req = "R10";
    for (int i = 0; i < 4; i++) step(1, 9'h020 + i, 1, 0);
    req = "R8 R5";
    while (q.size() > 0) step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    req = "R1";
    do_reset();
    req = "R10";
    step(1, 9'h011, 1, 0);
    step(1, 9'h012, 1, 0);
    req = "R6";
    for (int i = 0; i < 3; i++) step(1, 9'h0C0 + i, 0, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    req = "R7";
    step(0, 0, 1, 1);
    step(1, 9'h0D0, 0, 1);
    req = "R6";
    step(0, 0, 0, 1);
    while (q.size() > 0) step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    req = "R5";
    for (int i = 0; i < DEPTH / 2 + 1; i++) step(1, i, 0, 0);
    step(0, 0, 1, 0);
    step(1, 9'h077, 1, 0);
    step(0, 0, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule